// File: doc/BRIEF.md
# Five-Stage In-Order Toy Pipeline Core

This block is a small in-order processor core built as five single-cycle stages: fetch, decode with register read, execute, memory access and write-back. It runs a tiny two-operand instruction set in which the destination register is also the first source operand. It has four 8-bit registers and an 8-bit address space for both instruction and data memory. Both memories live outside the core and are read combinationally in the same cycle.

Two mechanisms keep dependent instructions correct. Results of add and subtract are forwarded into the execute stage, so a dependent instruction that follows them runs without a stall. When an arithmetic instruction needs the register that the instruction just ahead of it is loading, the core inserts exactly one bubble. During that bubble, fetch and decode hold their contents and an empty slot enters execute.

Store data is not forwarded. It is the register value read while the store sits in decode. The core raises a retire strobe for one cycle each time a real instruction finishes write-back. A bench or system observes progress through that strobe and through the data memory port.

Top module: `toy_pipe_core`

## Requirements
- R1: While reset is high at a clock edge, the next cycle shows retire low, no data write and instruction address 0. After reset all four registers read as zero.
- R2: An instruction word is 15 bits wide. Bits [14:12] hold the operation: 0 no-op, 1 load, 2 store, 3 add, 4 subtract, and 5 to 7 also no-op. Bits [11:10] hold the destination D, bits [9:8] the source S and bits [7:0] the memory address A. A load sets D to M[A], an add sets D to (D+S) mod 256, a subtract sets D to (D−S) mod 256, and a store writes D to M[A]. No-ops, including codes 5 to 7, change nothing.
- R3: Counting the cycle in which the address is driven as cycle k, an instruction fetched without a stall is in memory access in cycle k+3 and retires in cycle k+4. The fetch address advances by one every cycle in which no stall occurs.
- R4: An add or subtract that reads, through D or S, the register being loaded by the instruction directly ahead of it gets exactly one bubble. A load, then an add that depends on it, then a subtract that depends on the add retire in cycles 5, 7 and 8, with cycle 1 being the fetch of the load.
- R5: An instruction after a load that reads neither of the loaded register's roles gets no bubble. A load followed by two independent adds retires in cycles 5, 6 and 7.
- R6: An add or subtract result reaches the next one or two arithmetic instructions that read it without any stall. When several older instructions write the same register, the youngest one's value is used.
- R7: A store writes the value its D register held during the store's decode cycle, including a write-back that happens in that same cycle. A producer one or two instructions ahead of the store is therefore not seen, while a producer three ahead is seen. A load directly ahead of a store causes no bubble.
- R8: The retire strobe is high for one cycle for each load, store, add or subtract that finishes write-back. It stays low for no-ops and for injected bubbles.
- R9: The data write enable is high only in a store's memory-access cycle, with the store's address and data on the port, and that store retires in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr_o | output | 8 | Instruction fetch address (program counter) |
| imem_data_i | input | 15 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 8 | Data memory address for the instruction in memory access |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_wdata_o | output | 8 | Data memory write value |
| dmem_rdata_i | input | 8 | Data memory read value at dmem_addr_o, same cycle |
| retire_o | output | 1 | One-cycle pulse per completed instruction |

## Verification
The load, add and subtract chain is swept over every 8-bit load value. This pins the one-bubble timing and the wrap-around of the arithmetic. A two-load program with a longer arithmetic chain is swept over a grid of operand pairs. Its final values come out right only if the forwarding from both later pipeline registers, and the stall on a source-only dependency, all work. Separate programs place a producer at distances one, two and three ahead of a store, and put a load straight ahead of a store. These tell decode-time store data apart from forwarded data. Short programs with independent, destination-only and source-only dependents separate a needed bubble from a spurious one by their retire cycles.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;
    localparam int DATA_W   = 8;
    localparam int REG_AW   = 2;
    localparam int NUM_REGS = 1 << REG_AW;
    localparam int MEM_AW   = 8;
    localparam int PC_W     = 8;
    localparam int OP_W     = 3;
    localparam int INSTR_W  = OP_W + 2 * REG_AW + MEM_AW;
    localparam int RS_LSB   = MEM_AW;
    localparam int RD_LSB   = MEM_AW + REG_AW;
    localparam int OP_LSB   = MEM_AW + 2 * REG_AW;

    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [REG_AW-1:0]  reg_t;
    typedef logic [MEM_AW-1:0]  addr_t;
    typedef logic [PC_W-1:0]    pc_t;
    typedef logic [INSTR_W-1:0] instr_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 3'd0,
        OP_LD  = 3'd1,
        OP_ST  = 3'd2,
        OP_ADD = 3'd3,
        OP_SUB = 3'd4
    } op_e;

    typedef struct packed {
        op_e   op;
        reg_t  rd;
        reg_t  rs;
        addr_t addr;
        data_t a;
        data_t b;
    } idex_t;

    typedef struct packed {
        op_e   op;
        reg_t  rd;
        addr_t addr;
        data_t val;
    } exmem_t;

    typedef struct packed {
        op_e   op;
        reg_t  rd;
        data_t val;
    } memwb_t;

    localparam idex_t  IDEX_BUBBLE = '{op: OP_NOP, rd: '0, rs: '0, addr: '0, a: '0, b: '0};
    localparam exmem_t EXMEM_IDLE  = '{op: OP_NOP, rd: '0, addr: '0, val: '0};
    localparam memwb_t MEMWB_IDLE  = '{op: OP_NOP, rd: '0, val: '0};

    function automatic op_e decode_op(input logic [OP_W-1:0] raw);
        case (raw)
            3'd1:    return OP_LD;
            3'd2:    return OP_ST;
            3'd3:    return OP_ADD;
            3'd4:    return OP_SUB;
            default: return OP_NOP;
        endcase
    endfunction

    function automatic op_e field_op(input instr_t w);
        return decode_op(w[OP_LSB +: OP_W]);
    endfunction

    function automatic reg_t field_rd(input instr_t w);
        return w[RD_LSB +: REG_AW];
    endfunction

    function automatic reg_t field_rs(input instr_t w);
        return w[RS_LSB +: REG_AW];
    endfunction

    function automatic addr_t field_addr(input instr_t w);
        return w[0 +: MEM_AW];
    endfunction

    function automatic logic is_alu(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic writes_reg(input op_e op);
        return (op == OP_LD) || (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/tpc_fetch.sv
`timescale 1ns/1ps
module tpc_fetch
    import tpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  instr_t fetch_word,
    output pc_t    pc,
    output instr_t id_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            id_word <= '0;
        end else if (!hold) begin
            pc      <= pc + 1'b1;
            id_word <= fetch_word;
        end
    end
endmodule

// File: rtl/tpc_hazard.sv
`timescale 1ns/1ps
module tpc_hazard
    import tpc_pkg::*;
(
    input  op_e  id_op,
    input  reg_t id_rd,
    input  reg_t id_rs,
    input  op_e  ex_op,
    input  reg_t ex_rd,
    output logic stall
);
    logic reads_target;

    assign reads_target = is_alu(id_op) && ((id_rd == ex_rd) || (id_rs == ex_rd));
    assign stall        = (ex_op == OP_LD) && reads_target;
endmodule

// File: rtl/tpc_regfile.sv
`timescale 1ns/1ps
module tpc_regfile
    import tpc_pkg::*;
#(
    parameter int N_RD = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  reg_t  waddr,
    input  data_t wdata,
    input  reg_t  raddr [N_RD],
    output data_t rdata [N_RD]
);
    data_t cells [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                cells[k] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // write-through: a value retiring this cycle is visible to decode now
    for (genvar g = 0; g < N_RD; g++) begin : g_port
        assign rdata[g] = (we && (waddr == raddr[g])) ? wdata : cells[raddr[g]];
    end
endmodule

// File: rtl/tpc_execute.sv
`timescale 1ns/1ps
module tpc_execute
    import tpc_pkg::*;
(
    input  idex_t  ex,
    input  op_e    mem_op,
    input  reg_t   mem_rd,
    input  data_t  mem_val,
    input  op_e    wb_op,
    input  reg_t   wb_rd,
    input  data_t  wb_val,
    output exmem_t out
);
    localparam int N_SRC = 2;

    reg_t  src_reg [N_SRC];
    data_t src_rf  [N_SRC];
    data_t opnd    [N_SRC];

    assign src_reg[0] = ex.rd;
    assign src_reg[1] = ex.rs;
    assign src_rf[0]  = ex.a;
    assign src_rf[1]  = ex.b;

    // youngest producer wins: memory-stage ALU result, then write-back, then decode read
    for (genvar g = 0; g < N_SRC; g++) begin : g_fwd
        always_comb begin
            if (is_alu(mem_op) && (mem_rd == src_reg[g])) begin
                opnd[g] = mem_val;
            end else if (writes_reg(wb_op) && (wb_rd == src_reg[g])) begin
                opnd[g] = wb_val;
            end else begin
                opnd[g] = src_rf[g];
            end
        end
    end

    always_comb begin
        out.op   = ex.op;
        out.rd   = ex.rd;
        out.addr = ex.addr;
        case (ex.op)
            OP_ADD:  out.val = opnd[0] + opnd[1];
            OP_SUB:  out.val = opnd[0] - opnd[1];
            OP_ST:   out.val = ex.a;
            default: out.val = '0;
        endcase
    end
endmodule

// File: rtl/toy_pipe_core.sv
`timescale 1ns/1ps
module toy_pipe_core
    import tpc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr_o,
    input  logic [INSTR_W-1:0] imem_data_i,
    output logic [MEM_AW-1:0]  dmem_addr_o,
    output logic               dmem_we_o,
    output logic [DATA_W-1:0]  dmem_wdata_o,
    input  logic [DATA_W-1:0]  dmem_rdata_i,
    output logic               retire_o
);
    instr_t id_word;
    pc_t    pc;
    logic   stall;

    op_e    id_op;
    reg_t   id_rd;
    reg_t   id_rs;
    addr_t  id_addr;

    idex_t  idex_q;
    exmem_t ex_next;
    exmem_t exmem_q;
    memwb_t memwb_q;
    data_t  mem_result;

    reg_t   rf_raddr [2];
    data_t  rf_rdata [2];
    logic   wb_we;

    // ---------------- fetch ----------------
    tpc_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .hold       (stall),
        .fetch_word (imem_data_i),
        .pc         (pc),
        .id_word    (id_word)
    );

    assign imem_addr_o = pc;

    // ---------------- decode ----------------
    assign id_op   = field_op(id_word);
    assign id_rd   = field_rd(id_word);
    assign id_rs   = field_rs(id_word);
    assign id_addr = field_addr(id_word);

    tpc_hazard u_hazard (
        .id_op (id_op),
        .id_rd (id_rd),
        .id_rs (id_rs),
        .ex_op (idex_q.op),
        .ex_rd (idex_q.rd),
        .stall (stall)
    );

    assign rf_raddr[0] = id_rd;
    assign rf_raddr[1] = id_rs;
    assign wb_we       = writes_reg(memwb_q.op);

    tpc_regfile #(
        .N_RD (2)
    ) u_regfile (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_we),
        .waddr (memwb_q.rd),
        .wdata (memwb_q.val),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst || stall) begin
            idex_q <= IDEX_BUBBLE;
        end else begin
            idex_q <= '{op: id_op, rd: id_rd, rs: id_rs, addr: id_addr,
                        a: rf_rdata[0], b: rf_rdata[1]};
        end
    end

    // ---------------- execute ----------------
    tpc_execute u_execute (
        .ex      (idex_q),
        .mem_op  (exmem_q.op),
        .mem_rd  (exmem_q.rd),
        .mem_val (exmem_q.val),
        .wb_op   (memwb_q.op),
        .wb_rd   (memwb_q.rd),
        .wb_val  (memwb_q.val),
        .out     (ex_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exmem_q <= EXMEM_IDLE;
        end else begin
            exmem_q <= ex_next;
        end
    end

    // ---------------- memory access ----------------
    assign dmem_addr_o  = exmem_q.addr;
    assign dmem_we_o    = (exmem_q.op == OP_ST);
    assign dmem_wdata_o = exmem_q.val;
    assign mem_result   = (exmem_q.op == OP_LD) ? dmem_rdata_i : exmem_q.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            memwb_q <= MEMWB_IDLE;
        end else begin
            memwb_q <= '{op: exmem_q.op, rd: exmem_q.rd, val: mem_result};
        end
    end

    // ---------------- write-back ----------------
    assign retire_o = (memwb_q.op != OP_NOP);
endmodule

// File: rtl/toy_pipe_core_chk.sv
`timescale 1ns/1ps
module toy_pipe_core_chk
    import tpc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic stall,
    input pc_t  imem_addr,
    input logic retire,
    input logic dmem_we
);
    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && !stall) |=> (imem_addr == pc_t'($past(imem_addr) + 1'b1)));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && stall) |=> $stable(imem_addr));

    assert_bubble_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && stall) |-> ##3 !retire);

    assert_store_retires_R9: assert property (@(posedge clk) disable iff (rst)
        (!rst && dmem_we) |=> retire);
endmodule

bind toy_pipe_core toy_pipe_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .imem_addr (imem_addr_o),
    .retire    (retire_o),
    .dmem_we   (dmem_we_o)
);

// File: tb/toy_pipe_core_test.sv
`timescale 1ns/1ps
module toy_pipe_core_test;
    localparam int C_NOP = 0;
    localparam int C_LD  = 1;
    localparam int C_ST  = 2;
    localparam int C_ADD = 3;
    localparam int C_SUB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [14:0] imem_data;
    logic [7:0]  dmem_addr;
    logic        dmem_we;
    logic [7:0]  dmem_wdata;
    logic [7:0]  dmem_rdata;
    logic        retire;

    logic [14:0] imem [256];
    logic [7:0]  dmem [256];

    int n_run  = 0;
    int n_fail = 0;
    int nret;
    int nwe;
    int ret_cyc [64];
    int we_cyc  [64];
    int we_adr  [64];
    int we_dat  [64];

    always #2 clk = ~clk;

    toy_pipe_core uut (
        .clk          (clk),
        .rst          (rst),
        .imem_addr_o  (imem_addr),
        .imem_data_i  (imem_data),
        .dmem_addr_o  (dmem_addr),
        .dmem_we_o    (dmem_we),
        .dmem_wdata_o (dmem_wdata),
        .dmem_rdata_i (dmem_rdata),
        .retire_o     (retire)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    function automatic logic [14:0] enc(input int op, input int rd, input int rs, input int ad);
        return {3'(op), 2'(rd), 2'(rs), 8'(ad)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) imem[i] = enc(C_NOP, 0, 0, 0);
    endtask

    // cycle k is the k-th cycle counted from the one that fetches address 0
    task automatic run(input int ncyc, input bit chk_rst);
        nret = 0;
        nwe  = 0;
        rst  = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (chk_rst) begin
            chk("R1 retire in reset", int'(retire), 0);
            chk("R1 write enable in reset", int'(dmem_we), 0);
            chk("R1 fetch address in reset", int'(imem_addr), 0);
        end
        rst = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (retire && nret < 64) begin
                ret_cyc[nret] = i + 2;
                nret++;
            end
            if (dmem_we && nwe < 64) begin
                we_cyc[nwe] = i + 2;
                we_adr[nwe] = int'(dmem_addr);
                we_dat[nwe] = int'(dmem_wdata);
                nwe++;
            end
        end
        rst = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
        clear_prog();
        @(negedge clk);

        // ---- T1: reset state, no-op codes, store timing ----
        clear_prog();
        imem[1] = enc(7, 0, 0, 44);
        imem[2] = enc(5, 1, 2, 44);
        for (int r = 0; r < 4; r++) imem[3 + r] = enc(C_ST, r, 0, 40 + r);
        for (int a = 40; a < 45; a++) dmem[a] = 8'hFF;
        run(16, 1'b1);
        for (int r = 0; r < 4; r++) chk("R1 register zero after reset", int'(dmem[40 + r]), 0);
        chk("R2 opcode 5..7 is no-op (memory untouched)", int'(dmem[44]), 255);
        chk("R8 only real instructions retire", nret, 4);
        chk("R3 first store retire cycle", ret_cyc[0], 8);
        chk("R3 last store retire cycle", ret_cyc[3], 11);
        chk("R9 number of write cycles", nwe, 4);
        chk("R9 first write cycle", we_cyc[0], 7);
        chk("R9 first write address", we_adr[0], 40);
        chk("R9 first write data", we_dat[0], 0);
        chk("R9 last write address", we_adr[3], 43);

        // ---- T2: load / dependent add / dependent subtract, all load values ----
        for (int x = 0; x < 256; x++) begin
            clear_prog();
            imem[0] = enc(C_LD, 0, 0, 5);
            imem[1] = enc(C_ADD, 0, 0, 0);
            imem[2] = enc(C_SUB, 2, 0, 0);
            imem[6] = enc(C_ST, 0, 0, 50);
            imem[7] = enc(C_ST, 2, 0, 51);
            dmem[5] = 8'(x);
            run(16, 1'b0);
            chk("R2 add doubles loaded value", int'(dmem[50]), (2 * x) % 256);
            chk("R2 subtract wraps", int'(dmem[51]), (256 - (2 * x) % 256) % 256);
            if (x == 0 || x == 255) begin
                chk("R4 chain retire count", nret, 5);
                chk("R4 load retires cycle 5", ret_cyc[0], 5);
                chk("R4 dependent add retires cycle 7", ret_cyc[1], 7);
                chk("R4 chain ends cycle 8", ret_cyc[2], 8);
            end
        end

        // ---- T3: independent, source-only and destination-only dependents ----
        clear_prog();
        imem[0] = enc(C_LD, 0, 0, 5);
        imem[1] = enc(C_ADD, 1, 2, 0);
        imem[2] = enc(C_ADD, 3, 3, 0);
        dmem[5] = 8'd9;
        run(12, 1'b0);
        chk("R5 independent second retire", ret_cyc[1], 6);
        chk("R5 independent sequence ends cycle 7", ret_cyc[2], 7);

        clear_prog();
        imem[0] = enc(C_LD, 1, 0, 6);
        imem[1] = enc(C_SUB, 0, 1, 0);
        imem[5] = enc(C_ST, 0, 0, 36);
        dmem[6] = 8'd37;
        run(14, 1'b0);
        chk("R4 source-only dependent retire", ret_cyc[1], 7);
        chk("R4 source-only dependent value", int'(dmem[36]), 256 - 37);
        chk("R3 store after stall retire", ret_cyc[2], 11);

        clear_prog();
        imem[0] = enc(C_LD, 0, 0, 5);
        imem[1] = enc(C_ADD, 0, 2, 0);
        imem[5] = enc(C_ST, 0, 0, 37);
        dmem[5] = 8'd200;
        run(14, 1'b0);
        chk("R4 destination-only dependent retire", ret_cyc[1], 7);
        chk("R4 destination-only dependent value", int'(dmem[37]), 200);

        // ---- T4: operand grid through a longer forwarding chain ----
        for (int x = 0; x < 256; x += 3) begin
            for (int y = 0; y < 256; y += 11) begin
                clear_prog();
                imem[0]  = enc(C_LD, 0, 0, 0);
                imem[1]  = enc(C_LD, 1, 0, 1);
                imem[2]  = enc(C_ADD, 0, 1, 0);
                imem[3]  = enc(C_SUB, 1, 0, 0);
                imem[4]  = enc(C_ADD, 0, 1, 0);
                imem[5]  = enc(C_SUB, 0, 1, 0);
                imem[6]  = enc(C_ADD, 0, 0, 0);
                imem[10] = enc(C_ST, 0, 0, 32);
                imem[11] = enc(C_ST, 1, 0, 33);
                dmem[0] = 8'(x);
                dmem[1] = 8'(y);
                run(20, 1'b0);
                chk("R6 forwarded chain result", int'(dmem[32]), (2 * (x + y)) % 256);
                chk("R6 forwarded negate result", int'(dmem[33]), (256 - x) % 256);
                if (x == 0 && y == 0) begin
                    chk("R4 one bubble in grid program", ret_cyc[2], 8);
                    chk("R6 no stall along ALU chain", ret_cyc[6], 12);
                end
            end
        end

        // ---- T5: three writers of one register, youngest wins ----
        for (int v = 0; v < 8; v++) begin
            clear_prog();
            imem[0] = enc(C_LD, 0, 0, 0);
            imem[1] = enc(C_LD, 1, 0, 1);
            imem[3] = enc(C_ADD, 0, 1, 0);
            imem[4] = enc(C_ADD, 0, 1, 0);
            imem[5] = enc(C_ADD, 0, 1, 0);
            imem[9] = enc(C_ST, 0, 0, 34);
            dmem[0] = 8'(v * 31 + 7);
            dmem[1] = 8'(v * 53 + 90);
            run(16, 1'b0);
            chk("R6 youngest producer wins", int'(dmem[34]), ((v * 31 + 7) + 3 * (v * 53 + 90)) % 256);
            chk("R6 back-to-back adds unstalled", ret_cyc[4], 10);
            chk("R8 retire count with no-ops", nret, 6);
        end

        // ---- T6: store data taken at decode ----
        for (int v = 0; v < 6; v++) begin
            int a;
            int b;
            int c;
            a = (v * 41 + 3) % 256;
            b = (v * 29 + 17) % 256;
            c = (v * 67 + 1) % 256;
            clear_prog();
            imem[0]  = enc(C_LD, 2, 0, 2);
            imem[1]  = enc(C_LD, 3, 0, 3);
            imem[5]  = enc(C_ADD, 2, 3, 0);
            imem[6]  = enc(C_ST, 2, 0, 60);
            imem[7]  = enc(C_ADD, 2, 3, 0);
            imem[9]  = enc(C_ST, 2, 0, 61);
            imem[10] = enc(C_ADD, 2, 3, 0);
            imem[13] = enc(C_ST, 2, 0, 62);
            imem[14] = enc(C_LD, 1, 0, 4);
            imem[15] = enc(C_ST, 1, 0, 63);
            imem[19] = enc(C_ST, 1, 0, 64);
            dmem[2] = 8'(a);
            dmem[3] = 8'(b);
            dmem[4] = 8'(c);
            run(26, 1'b0);
            chk("R7 producer one ahead not seen", int'(dmem[60]), a);
            chk("R7 producer two ahead not seen", int'(dmem[61]), (a + b) % 256);
            chk("R7 producer three ahead seen", int'(dmem[62]), (a + 3 * b) % 256);
            chk("R7 load straight ahead not seen", int'(dmem[63]), 0);
            chk("R7 load seen after gap", int'(dmem[64]), c);
            chk("R7 load then store without bubble", ret_cyc[9], 20);
            chk("R8 retire count store program", nret, 11);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule